// File: doc/BRIEF.md
# Queue Interrupt Source Controller

This block raises the interrupt requests for a hardware queue manager that serves 64 queues, split into a lower and an upper half of 32. Each lower queue presents four status flags. Software chooses, per queue, which flag triggers its interrupt and whether that flag is inverted first. The upper queues have no such choice: each one interrupts when it stops being nearly empty. All status inputs are registered once and can be read back.

A rising edge of a queue's chosen condition sets its pending bit, but only while that queue's enable bit is set. Pending bits are cleared by writing ones to them. Each half drives its own interrupt line, which is high while any of its queues is both pending and enabled. Each half also reports the number of the highest such queue, with a valid flag, so a handler can serve that queue without scanning.

Software reaches the block over a single-cycle register port. A write takes effect at the clock edge. A read returns the addressed word combinationally from the current register state. Word addresses: 0–3 source select, 4–7 lower status, 8 lower enable, 9 upper enable, 10 lower pending, 11 upper pending, 12 upper nearly-empty status, 13 upper full status. Every other address reads as zero, and writes to the status words and to unused addresses are ignored.

Top module: `qirq_ctrl`

## Requirements
- R1: Synchronous reset sets all source fields, both enable words and both pending words to zero. The lower status words become 0x33333333, upper nearly-empty becomes all ones and upper full becomes all zeros. These values hold while reset is asserted, whatever the status inputs are.
- R2: Lower queue q owns bits [4*(q%8)+2 : 4*(q%8)] of source word q/8 (address q/8). Field bits [1:0] select flag 0–3 of that queue, and field bit 2 inverts the selected flag. Bit 3 of each nibble is reserved: it reads 0 and writes to it are dropped.
- R3: The condition of upper queue 32+k is the inverse of nearly-empty input bit k. The source words have no effect on it.
- R4: A pending bit is set at the second clock edge after a rising edge of its condition appears on the status inputs, provided its enable bit was set at that edge. A condition that stays high, or a rising edge while the queue is disabled, sets nothing.
- R5: Writing a pending word clears each bit written as 1 and leaves bits written as 0 unchanged. Pending bits are not cleared in any other way.
- R6: When a set and a write-one clear hit the same pending bit on the same edge, the bit ends up set.
- R7: Enable bit k of a half applies to queue k of that half. Each interrupt output is high exactly when some bit of its half is both pending and enabled.
- R8: Each half reports the index of its highest-numbered bit that is both pending and enabled, and a valid flag that is high whenever such a bit exists.
- R9: Clearing an enable bit leaves the pending bit set and only masks it. The pending bit goes away only after a write-one to the pending word.
- R10: Lower status nibble q sits at bits [4*(q%8)+3 : 4*(q%8)] of status word q/8 (address 4+q/8). It and the upper status words show the inputs as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| lo_flags | input | 128 | Four status flags per lower queue, nibble q at [4q+3:4q] |
| hi_nearly_empty | input | 32 | Nearly-empty flag per upper queue |
| hi_full | input | 32 | Full flag per upper queue |
| irq_lo | output | 1 | Interrupt request, lower half |
| irq_hi | output | 1 | Interrupt request, upper half |
| top_lo_idx | output | 5 | Highest live queue, lower half |
| top_lo_vld | output | 1 | top_lo_idx is meaningful |
| top_hi_idx | output | 5 | Highest live queue, upper half (index within half) |
| top_hi_vld | output | 1 | top_hi_idx is meaningful |

## Verification
The bench builds the block at its default size: 32 queues per half, 4 flags per queue and 32-bit words, so every queue number, both ends of each index range and all eight source-field codes can be reached. Directed sequences set up exact collisions, such as a set meeting a clear on the same edge, and the two-step disable. A long random phase then drives all 64 conditions and random writes to every address at once, which exercises the priority encoder with many bits live together.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

    localparam int HALF_Q      = 32;
    localparam int DW          = 32;
    localparam int AW          = 4;
    localparam int FLAGS       = 4;
    localparam int FIELD_W     = 4;
    localparam int SEL_W       = 3;
    localparam int SRC_PER_REG = DW / FIELD_W;
    localparam int SRC_REGS    = HALF_Q / SRC_PER_REG;
    localparam int IDX_W       = $clog2(HALF_Q);

    localparam logic [AW-1:0] A_SRC0    = 4'd0;
    localparam logic [AW-1:0] A_LST0    = 4'd4;
    localparam logic [AW-1:0] A_EN_LO   = 4'd8;
    localparam logic [AW-1:0] A_EN_HI   = 4'd9;
    localparam logic [AW-1:0] A_PEND_LO = 4'd10;
    localparam logic [AW-1:0] A_PEND_HI = 4'd11;
    localparam logic [AW-1:0] A_HNE     = 4'd12;
    localparam logic [AW-1:0] A_HFULL   = 4'd13;

    localparam logic [FLAGS-1:0] LST_RST = 4'h3;

    typedef struct packed {
        logic       inv;
        logic [1:0] pick;
    } src_sel_t;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_wr_t;

    function automatic logic sel_cond(input logic [FLAGS-1:0] flags, input src_sel_t s);
        return flags[s.pick] ^ s.inv;
    endfunction

endpackage

// File: rtl/qirq_cfg.sv
module qirq_cfg
    import qirq_pkg::*;
#(
    parameter int N = HALF_Q
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_wr_t              bus,
    output src_sel_t [N-1:0]     src_sel,
    output logic     [N-1:0]     en_lo,
    output logic     [N-1:0]     en_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_sel <= '0;
        end else if (bus.wr) begin
            for (int q = 0; q < N; q++) begin
                if (bus.addr == AW'(int'(A_SRC0) + q / SRC_PER_REG)) begin
                    src_sel[q] <= src_sel_t'(bus.data[FIELD_W*(q % SRC_PER_REG) +: SEL_W]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_lo <= '0;
            en_hi <= '0;
        end else if (bus.wr) begin
            if (bus.addr == A_EN_LO) en_lo <= bus.data[N-1:0];
            if (bus.addr == A_EN_HI) en_hi <= bus.data[N-1:0];
        end
    end

endmodule

// File: rtl/qirq_cond.sv
module qirq_cond
    import qirq_pkg::*;
#(
    parameter int N = HALF_Q
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [FLAGS*N-1:0]     lo_flags,
    input  logic [N-1:0]           hi_ne,
    input  logic [N-1:0]           hi_full,
    input  src_sel_t [N-1:0]       src_sel,
    output logic [FLAGS*N-1:0]     lst_q,
    output logic [N-1:0]           hne_q,
    output logic [N-1:0]           hfull_q,
    output logic [N-1:0]           rise_lo,
    output logic [N-1:0]           rise_hi
);

    logic [N-1:0] cond_lo, cond_hi;
    logic [N-1:0] prev_lo, prev_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            lst_q   <= {N{LST_RST}};
            hne_q   <= '1;
            hfull_q <= '0;
            prev_lo <= '0;
            prev_hi <= '0;
        end else begin
            lst_q   <= lo_flags;
            hne_q   <= hi_ne;
            hfull_q <= hi_full;
            prev_lo <= cond_lo;
            prev_hi <= cond_hi;
        end
    end

    always_comb begin
        for (int q = 0; q < N; q++) begin
            cond_lo[q] = sel_cond(lst_q[FLAGS*q +: FLAGS], src_sel[q]);
        end
        cond_hi = ~hne_q;
    end

    assign rise_lo = cond_lo & ~prev_lo;
    assign rise_hi = cond_hi & ~prev_hi;

endmodule

// File: rtl/qirq_half.sv
module qirq_half #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  rise,
    input  logic [N-1:0]  en,
    input  logic          clr_we,
    input  logic [N-1:0]  clr_mask,
    output logic [N-1:0]  pend,
    output logic          irq,
    output logic [IW-1:0] idx,
    output logic          vld
);

    logic [N-1:0] clr;
    logic [N-1:0] live;

    assign clr = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | (rise & en);
    end

    assign live = pend & en;
    assign irq  = |live;

    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (live[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
    import qirq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic [FLAGS*HALF_Q-1:0]  lo_flags,
    input  logic [HALF_Q-1:0]        hi_nearly_empty,
    input  logic [HALF_Q-1:0]        hi_full,
    output logic                     irq_lo,
    output logic                     irq_hi,
    output logic [IDX_W-1:0]         top_lo_idx,
    output logic                     top_lo_vld,
    output logic [IDX_W-1:0]         top_hi_idx,
    output logic                     top_hi_vld
);

    bus_wr_t                    bus;
    src_sel_t [HALF_Q-1:0]      src_sel;
    logic [HALF_Q-1:0]          en_lo, en_hi;
    logic [HALF_Q-1:0]          pend_lo, pend_hi;
    logic [HALF_Q-1:0]          rise_lo, rise_hi;
    logic [HALF_Q-1:0]          hne_q, hfull_q;
    logic [FLAGS*HALF_Q-1:0]    lst_q;

    logic [HALF_Q-1:0]          rise_v [2];
    logic [HALF_Q-1:0]          en_v   [2];
    logic [HALF_Q-1:0]          pend_v [2];
    logic                       irq_v  [2];
    logic [IDX_W-1:0]           idx_v  [2];
    logic                       vld_v  [2];

    assign bus = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    qirq_cfg #(.N(HALF_Q)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .src_sel (src_sel),
        .en_lo   (en_lo),
        .en_hi   (en_hi)
    );

    qirq_cond #(.N(HALF_Q)) u_cond (
        .clk      (clk),
        .rst      (rst),
        .lo_flags (lo_flags),
        .hi_ne    (hi_nearly_empty),
        .hi_full  (hi_full),
        .src_sel  (src_sel),
        .lst_q    (lst_q),
        .hne_q    (hne_q),
        .hfull_q  (hfull_q),
        .rise_lo  (rise_lo),
        .rise_hi  (rise_hi)
    );

    assign rise_v[0] = rise_lo;
    assign rise_v[1] = rise_hi;
    assign en_v[0]   = en_lo;
    assign en_v[1]   = en_hi;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [AW-1:0] PA = (h == 0) ? A_PEND_LO : A_PEND_HI;
        qirq_half #(.N(HALF_Q)) u_half (
            .clk      (clk),
            .rst      (rst),
            .rise     (rise_v[h]),
            .en       (en_v[h]),
            .clr_we   (bus.wr && (bus.addr == PA)),
            .clr_mask (bus.data[HALF_Q-1:0]),
            .pend     (pend_v[h]),
            .irq      (irq_v[h]),
            .idx      (idx_v[h]),
            .vld      (vld_v[h])
        );
    end

    assign pend_lo    = pend_v[0];
    assign pend_hi    = pend_v[1];
    assign irq_lo     = irq_v[0];
    assign irq_hi     = irq_v[1];
    assign top_lo_idx = idx_v[0];
    assign top_hi_idx = idx_v[1];
    assign top_lo_vld = vld_v[0];
    assign top_hi_vld = vld_v[1];

    always_comb begin
        bus_rdata = '0;
        for (int q = 0; q < HALF_Q; q++) begin
            if (bus_addr == AW'(int'(A_SRC0) + q / SRC_PER_REG)) begin
                bus_rdata[FIELD_W*(q % SRC_PER_REG) +: SEL_W] = src_sel[q];
            end
        end
        for (int r = 0; r < SRC_REGS; r++) begin
            if (bus_addr == AW'(int'(A_LST0) + r)) begin
                bus_rdata = lst_q[DW*r +: DW];
            end
        end
        case (bus_addr)
            A_EN_LO:   bus_rdata = en_lo;
            A_EN_HI:   bus_rdata = en_hi;
            A_PEND_LO: bus_rdata = pend_lo;
            A_PEND_HI: bus_rdata = pend_hi;
            A_HNE:     bus_rdata = hne_q;
            A_HFULL:   bus_rdata = hfull_q;
            default:   ;
        endcase
    end

endmodule

// File: rtl/qirq_ctrl_chk.sv
module qirq_ctrl_chk
    import qirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [HALF_Q-1:0] pend_lo,
    input logic [HALF_Q-1:0] pend_hi,
    input logic [HALF_Q-1:0] en_lo,
    input logic [HALF_Q-1:0] en_hi,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic [IDX_W-1:0]  top_lo_idx,
    input logic              top_lo_vld,
    input logic [IDX_W-1:0]  top_hi_idx,
    input logic              top_hi_vld
);

    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_lo == '0 && pend_hi == '0 && en_lo == '0 && en_hi == '0));

    p_set_needs_en_lo_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_lo & ~$past(pend_lo) & ~$past(en_lo)) == '0));

    p_set_needs_en_hi_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_hi & ~$past(pend_hi) & ~$past(en_hi)) == '0));

    p_drop_needs_clear_lo_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(bus_wr) && $past(bus_addr) == A_PEND_LO))
            |-> (($past(pend_lo) & ~pend_lo) == '0));

    p_drop_needs_clear_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(bus_wr) && $past(bus_addr) == A_PEND_HI))
            |-> (($past(pend_hi) & ~pend_hi) == '0));

    p_irq_vs_valid_lo_r7: assert property (@(posedge clk) disable iff (rst)
        irq_lo == top_lo_vld);

    p_irq_vs_valid_hi_r7: assert property (@(posedge clk) disable iff (rst)
        irq_hi == top_hi_vld);

    p_idx_live_lo_r8: assert property (@(posedge clk) disable iff (rst)
        top_lo_vld |-> (pend_lo[top_lo_idx] && en_lo[top_lo_idx]));

    p_idx_live_hi_r8: assert property (@(posedge clk) disable iff (rst)
        top_hi_vld |-> (pend_hi[top_hi_idx] && en_hi[top_hi_idx]));

endmodule

bind qirq_ctrl qirq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .pend_lo    (pend_lo),
    .pend_hi    (pend_hi),
    .en_lo      (en_lo),
    .en_hi      (en_hi),
    .irq_lo     (irq_lo),
    .irq_hi     (irq_hi),
    .top_lo_idx (top_lo_idx),
    .top_lo_vld (top_lo_vld),
    .top_hi_idx (top_hi_idx),
    .top_hi_vld (top_hi_vld)
);

// File: tb/qirq_ctrl_bench.sv
`timescale 1ns/1ps
module qirq_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_wr;
    logic [3:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [127:0] lo_flags;
    logic [31:0]  hi_nearly_empty;
    logic [31:0]  hi_full;
    logic         irq_lo, irq_hi, top_lo_vld, top_hi_vld;
    logic [4:0]   top_lo_idx, top_hi_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    qirq_ctrl u_qirq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lo_flags(lo_flags),
        .hi_nearly_empty(hi_nearly_empty), .hi_full(hi_full),
        .irq_lo(irq_lo), .irq_hi(irq_hi),
        .top_lo_idx(top_lo_idx), .top_lo_vld(top_lo_vld),
        .top_hi_idx(top_hi_idx), .top_hi_vld(top_hi_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0]  m_src [32];
    logic [3:0]  m_lst [32];
    logic [31:0] m_hne, m_hfull;
    logic [31:0] m_en [2];
    logic [31:0] m_pend [2];
    logic [31:0] m_prev [2];
    logic [31:0] t_cond [2];
    logic [31:0] t_clr [2];

    function automatic logic flag_of(input logic [3:0] nib, input logic [2:0] sel);
        logic [3:0] shifted;
        shifted = nib >> sel[1:0];
        return shifted[0] ^ sel[2];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < 32; q++) begin
                m_src[q] = 3'd0;
                m_lst[q] = 4'h3;
            end
            m_hne = '1; m_hfull = '0;
            for (int h = 0; h < 2; h++) begin
                m_en[h] = '0; m_pend[h] = '0; m_prev[h] = '0;
            end
        end else begin
            for (int q = 0; q < 32; q++) t_cond[0][q] = flag_of(m_lst[q], m_src[q]);
            t_cond[1] = ~m_hne;
            t_clr[0] = (bus_wr && bus_addr == 4'd10) ? bus_wdata : 32'h0;
            t_clr[1] = (bus_wr && bus_addr == 4'd11) ? bus_wdata : 32'h0;
            for (int h = 0; h < 2; h++) begin
                m_pend[h] = (m_pend[h] & ~t_clr[h]) | (t_cond[h] & ~m_prev[h] & m_en[h]);
                m_prev[h] = t_cond[h];
            end
            if (bus_wr) begin
                if (bus_addr < 4'd4)
                    for (int j = 0; j < 8; j++) m_src[bus_addr*8 + j] = bus_wdata[4*j +: 3];
                if (bus_addr == 4'd8) m_en[0] = bus_wdata;
                if (bus_addr == 4'd9) m_en[1] = bus_wdata;
            end
            for (int q = 0; q < 32; q++) m_lst[q] = lo_flags[4*q +: 4];
            m_hne = hi_nearly_empty;
            m_hfull = hi_full;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        logic [31:0] w;
        w = '0;
        if (a < 4'd4) begin
            for (int j = 0; j < 8; j++) w[4*j +: 3] = m_src[a*8 + j];
        end else if (a < 4'd8) begin
            for (int j = 0; j < 8; j++) w[4*j +: 4] = m_lst[(a-4)*8 + j];
        end else begin
            case (a)
                4'd8:  w = m_en[0];
                4'd9:  w = m_en[1];
                4'd10: w = m_pend[0];
                4'd11: w = m_pend[1];
                4'd12: w = m_hne;
                4'd13: w = m_hfull;
                default: w = '0;
            endcase
        end
        return w;
    endfunction

    function automatic int top_bit(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic string req_of(input logic [3:0] a);
        if (a < 4'd4) return "R2 source readback";
        if (a < 4'd8 || a == 4'd12 || a == 4'd13) return "R10 status readback";
        if (a == 4'd8 || a == 4'd9) return "R7 enable readback";
        if (a == 4'd10 || a == 4'd11) return "R4 pending readback";
        return "R2 unused address";
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] live0, live1;
            int t0, t1;
            live0 = m_pend[0] & m_en[0];
            live1 = m_pend[1] & m_en[1];
            t0 = top_bit(live0);
            t1 = top_bit(live1);
            chk("R7 irq_lo", {31'd0, irq_lo}, {31'd0, live0 != 0});
            chk("R7 irq_hi", {31'd0, irq_hi}, {31'd0, live1 != 0});
            chk("R8 lo valid", {31'd0, top_lo_vld}, {31'd0, t0 >= 0});
            chk("R8 hi valid", {31'd0, top_hi_vld}, {31'd0, t1 >= 0});
            if (t0 >= 0) chk("R8 lo index", {27'd0, top_lo_idx}, 32'(t0));
            if (t1 >= 0) chk("R8 hi index", {27'd0, top_hi_idx}, 32'(t1));
            chk(req_of(bus_addr), bus_rdata, m_read(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        step();
        bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
    endtask

    task automatic out_chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        @(negedge clk);
        chk(req, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        lo_flags = '0; hi_nearly_empty = '0; hi_full = '1;
        idle(2);
        // R1: reset values while reset is held, inputs deliberately different
        rd_chk(4'd0,  32'h0,        "R1 source");
        rd_chk(4'd3,  32'h0,        "R1 source");
        rd_chk(4'd4,  32'h33333333, "R1 lower status");
        rd_chk(4'd7,  32'h33333333, "R1 lower status");
        rd_chk(4'd8,  32'h0,        "R1 enable lo");
        rd_chk(4'd9,  32'h0,        "R1 enable hi");
        rd_chk(4'd10, 32'h0,        "R1 pending lo");
        rd_chk(4'd11, 32'h0,        "R1 pending hi");
        rd_chk(4'd12, 32'hffffffff, "R1 nearly-empty");
        rd_chk(4'd13, 32'h0,        "R1 full");
        out_chk("R1 irq_lo", {31'd0, irq_lo}, 32'h0);

        lo_flags = {32{4'h3}}; hi_nearly_empty = '1; hi_full = '0;
        step();
        rst = 1'b0;
        idle(2);

        // R2: reserved bits of source fields
        wr(4'd1, 32'hffffffff);
        rd_chk(4'd1, 32'h77777777, "R2 reserved bit");

        // R4: queue 5 selects flag 2, rising edge while enabled
        wr(4'd0, 32'h0020_0000);
        wr(4'd8, 32'h0000_0020);
        step(); lo_flags[22] = 1'b1;
        idle(3);
        rd_chk(4'd10, 32'h0000_0020, "R4 set on edge");
        out_chk("R7 irq_lo", {31'd0, irq_lo}, 32'h1);
        out_chk("R8 lo index", {27'd0, top_lo_idx}, 32'd5);

        // R5: write-zero keeps, write-one clears; held condition does not re-set
        wr(4'd10, 32'h0);
        rd_chk(4'd10, 32'h0000_0020, "R5 write zero");
        wr(4'd10, 32'h0000_0020);
        rd_chk(4'd10, 32'h0, "R5 write one");
        idle(2);
        rd_chk(4'd10, 32'h0, "R4 level held");

        // R6: set and clear on the same edge
        step(); lo_flags[22] = 1'b0;
        idle(3);
        step(); lo_flags[22] = 1'b1;
        step(); bus_wr = 1'b1; bus_addr = 4'd10; bus_wdata = 32'h0000_0020;
        step();
        rd_chk(4'd10, 32'h0000_0020, "R6 set wins");

        // R8: second lower queue (30, flag 0)
        wr(4'd8, 32'h4000_0020);
        step(); lo_flags[120] = 1'b0;
        idle(3);
        step(); lo_flags[120] = 1'b1;
        idle(3);
        rd_chk(4'd10, 32'h4000_0020, "R8 two pending");
        out_chk("R8 highest lo", {27'd0, top_lo_idx}, 32'd30);

        // R9: two-step disable
        wr(4'd8, 32'h0000_0020);
        rd_chk(4'd10, 32'h4000_0020, "R9 pending kept");
        out_chk("R9 index masked", {27'd0, top_lo_idx}, 32'd5);
        wr(4'd10, 32'h4000_0000);
        rd_chk(4'd10, 32'h0000_0020, "R9 after clear");
        wr(4'd8, 32'h0);
        out_chk("R9 irq masked", {31'd0, irq_lo}, 32'h0);
        out_chk("R9 valid masked", {31'd0, top_lo_vld}, 32'h0);
        rd_chk(4'd10, 32'h0000_0020, "R9 still pending");
        wr(4'd10, 32'h0000_0020);
        rd_chk(4'd10, 32'h0, "R9 cleared");
        step(); lo_flags[120] = 1'b0;
        idle(3);
        step(); lo_flags[120] = 1'b1;
        idle(3);
        rd_chk(4'd10, 32'h0, "R4 disabled edge");

        // R3: upper half interrupts when nearly-empty drops
        wr(4'd9, 32'h0010_0008);
        step(); hi_nearly_empty[3] = 1'b0;
        idle(3);
        out_chk("R3 irq_hi", {31'd0, irq_hi}, 32'h1);
        out_chk("R3 hi index", {27'd0, top_hi_idx}, 32'd3);
        rd_chk(4'd11, 32'h0000_0008, "R3 pending hi");
        step(); hi_nearly_empty[20] = 1'b0;
        idle(3);
        out_chk("R8 highest hi", {27'd0, top_hi_idx}, 32'd20);
        rd_chk(4'd11, 32'h0010_0008, "R3 pending hi two");
        rd_chk(4'd12, 32'hffef_fff7, "R10 nearly-empty status");
        wr(4'd11, 32'hffffffff);
        rd_chk(4'd11, 32'h0, "R5 clear all hi");

        // R2: inverted flag 3 on queue 12
        wr(4'd8, 32'h0000_1000);
        step(); lo_flags[51] = 1'b1;
        idle(3);
        rd_chk(4'd10, 32'h0, "R2 inverted fall");
        step(); lo_flags[51] = 1'b0;
        idle(3);
        rd_chk(4'd10, 32'h0000_1000, "R2 inverted rise");

        // R10: lower status layout
        step(); lo_flags[39:36] = 4'ha;
        rd_chk(4'd5, 32'h3333_33a3, "R10 lower status");
        wr(4'd10, 32'hffffffff);

        // random phase, compared each cycle against the model
        for (int c = 0; c < 4000; c++) begin
            step();
            lo_flags[$urandom_range(127, 0)] ^= 1'b1;
            if ($urandom_range(3, 0) == 0) hi_nearly_empty[$urandom_range(31, 0)] ^= 1'b1;
            if ($urandom_range(7, 0) == 0) hi_full[$urandom_range(31, 0)] ^= 1'b1;
            bus_addr = 4'($urandom_range(15, 0));
            if ($urandom_range(3, 0) == 0) begin
                bus_wr = 1'b1;
                bus_wdata = $urandom;
            end
        end
        step();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule